// File: doc/BRIEF.md
# Idle-Locking Stream Descrambler

This block recovers plaintext from a scrambled serial stream. Each clock it takes zero, one or two ciphertext bits and a count of how many are present. It XORs each bit with a keystream from an 11-bit LFSR built on x^11 + x^9 + 1, and passes the result on with the same count one cycle later. The keystream is never sent, so the block has to find it alone. While unlocked it pushes each received bit, inverted, into the keystream register. The line sends idle as all-ones plaintext, so after eleven idle bits the register holds the sender's state.

A saturating counter measures the current run of descrambled ones. When the registered run reaches the lock threshold, the block raises its locked flag. After that, each new qualifying run restarts an unlock timer. If the timer runs out before another run is seen, lock is dropped. The timer is an LFSR that steps once per clock and is compared against a terminal state computed at elaboration. A test input selects a short window in place of the normal one. When the signal-status input is low, the block goes unlocked at once, but data keeps flowing.

Top module: `idle_lock_descrambler`

## Requirements
- R1: While reset is asserted, and after it is released, `locked`, `dsc_cnt` and `dsc_bits` read zero.
- R2: `dsc_cnt` equals the `scr_cnt` of the previous clock. This holds whatever the values of `sig_ok`, `locked` and `short_timeout`.
- R3: With a count of 2, `scr_bits[0]` is the earlier bit in line order and `scr_bits[1]` the later one. With a count of 1, only `scr_bits[0]` is used. Any output bit at or above the output count reads 0.
- R4: While locked, each valid output bit equals its ciphertext bit XOR the sender's keystream bit, one cycle after input. The keystream bit is state[10] XOR state[8], and that bit is then shifted into state[0].
- R5: A cycle with count 0 neither advances the keystream nor breaks an idle run in progress.
- R6: While unlocked, the inverted ciphertext is shifted into the keystream register. `locked` rises on the clock after the registered run of consecutive ones reaches 30. With two idle bits per clock from reset, the block is still unlocked after 15 clocks and is locked after 22.
- R7: A zero plaintext bit clears the run. Runs shorter than 30 never lock, and a run may span cycles with mixed counts of 0, 1 and 2.
- R8: With `short_timeout` low, lock clears exactly 45126 clocks after the clock at which the last qualifying run ends (125 MHz × 361 us, plus one).
- R9: With `short_timeout` high, the same interval is 626 clocks (125 MHz × 5 us, plus one).
- R10: A registered run of at least 30 restarts the unlock timer. Lock never clears on timeout while such a run is present.
- R11: `sig_ok` low clears `locked` and the run count at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scr_bits | input | 2 | Ciphertext bits; bit 0 is the earlier one |
| scr_cnt | input | 2 | Number of valid ciphertext bits (0, 1 or 2) |
| sig_ok | input | 1 | Signal-status flag from the line receiver |
| short_timeout | input | 1 | Selects the short unlock window |
| dsc_bits | output | 2 | Descrambled bits; unused positions read 0 |
| dsc_cnt | output | 2 | Number of valid descrambled bits |
| locked | output | 1 | Keystream synchronised |

## Verification
Loss of signal status and data flow can fall in the same cycle. One clock both clears lock and still has to carry two ciphertext bits through to the output. The bench drops `sig_ok` for a single clock in the middle of a locked two-bit stream. It then checks that `locked` is low after that edge and that `dsc_cnt` still reports the two bits. A second overlap is expiry of the unlock window against a new idle run. The bench repeats short idle bursts in test mode, so the window is refreshed many times over a span longer than the window itself, and checks that lock survives.

// File: rtl/desc_pkg.sv
package desc_pkg;

   typedef logic [1:0] bit_pair_t;
   typedef logic [1:0] bit_cnt_t;

   localparam int unsigned LANES = 2;

   // tap masks for the timer LFSR, feedback = parity(state & mask), shift left
   function automatic logic [23:0] timer_taps(input int unsigned w);
      logic [23:0] m;
      case (w)
         16:      m = 24'h00B400;
         20:      m = 24'h090000;
         default: m = 24'hE10000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/desc_keystream.sv
module desc_keystream
   import desc_pkg::*;
#(
   parameter int unsigned KS_W   = 11,
   parameter int unsigned KS_TAP = 9
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      locked,
   input  bit_pair_t cin,
   input  bit_cnt_t  cnt,
   output bit_pair_t plain,
   output bit_pair_t out_bits,
   output bit_cnt_t  out_cnt
);

   if (KS_TAP < 1 || KS_TAP >= KS_W) begin : g_bad_tap
      $error("desc_keystream: KS_TAP must lie in 1..KS_W-1");
   end

   logic [KS_W-1:0] st_q;
   logic [KS_W-1:0] chain [0:LANES];
   logic [LANES-1:0] use_b;

   assign use_b    = {cnt[1], |cnt};
   assign chain[0] = st_q;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic kbit;
      assign kbit     = chain[i][KS_W-1] ^ chain[i][KS_TAP-1];
      assign plain[i] = use_b[i] & (cin[i] ^ kbit);
      assign chain[i+1] = use_b[i] ?
         {chain[i][KS_W-2:0], (locked ? kbit : ~cin[i])} : chain[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= '1;
         out_bits <= '0;
         out_cnt  <= '0;
      end else begin
         st_q     <= chain[LANES];
         out_bits <= plain;
         out_cnt  <= cnt;
      end
   end

endmodule

// File: rtl/desc_idle_run.sv
module desc_idle_run
   import desc_pkg::*;
#(
   parameter int unsigned IW  = 6,
   parameter int unsigned RUN = 30
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clear,
   input  bit_pair_t plain,
   input  bit_cnt_t  cnt,
   output logic      run_ok
);

   localparam logic [IW-1:0] MAXV = '1;
   localparam logic [IW-1:0] RUNV = IW'(RUN);

   if (RUN < 1 || RUN > (2**IW) - 2) begin : g_bad_run
      $error("desc_idle_run: RUN must fit below the counter ceiling");
   end

   logic [IW-1:0] run_q, n0, n1;

   function automatic logic [IW-1:0] bump(input logic [IW-1:0] v, input logic b);
      if (!b)        return '0;
      if (v == MAXV) return v;
      return v + 1'b1;
   endfunction

   always_comb begin
      n0 = (|cnt)  ? bump(run_q, plain[0]) : run_q;
      n1 = cnt[1]  ? bump(n0, plain[1])    : n0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= '0;
      else if (clear) run_q <= '0;
      else            run_q <= n1;
   end

   assign run_ok = (run_q >= RUNV);

endmodule

// File: rtl/desc_unlock_timer.sv
module desc_unlock_timer
   import desc_pkg::*;
#(
   parameter int unsigned TW       = 16,
   parameter int unsigned N_NORM   = 45125,
   parameter int unsigned N_SHORT  = 625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic short_sel,
   output logic expired
);

   if (TW != 16 && TW != 20 && TW != 24) begin : g_bad_tw
      $error("desc_unlock_timer: TW must be 16, 20 or 24");
   end
   if (N_SHORT >= N_NORM || N_NORM >= (2**TW) - 1) begin : g_bad_n
      $error("desc_unlock_timer: windows must be ordered and below the LFSR period");
   end

   localparam logic [23:0]   TAPS_ALL = timer_taps(TW);
   localparam logic [TW-1:0] TAPS     = TAPS_ALL[TW-1:0];
   localparam logic [TW-1:0] SEED     = '1;

   function automatic logic [TW-1:0] step_f(input logic [TW-1:0] v);
      return {v[TW-2:0], ^(v & TAPS)};
   endfunction

   function automatic logic [TW-1:0] apply_f(input logic [TW*TW-1:0] m,
                                             input logic [TW-1:0]    v);
      logic [TW-1:0] r;
      r = '0;
      for (int j = 0; j < TW; j++)
         if (v[j]) r = r ^ m[j*TW +: TW];
      return r;
   endfunction

   // state after n steps from s, via repeated squaring of the step matrix
   function automatic logic [TW-1:0] jump_f(input logic [TW-1:0] s,
                                            input int unsigned   n);
      logic [TW*TW-1:0] p, q;
      logic [TW-1:0]    e, v;
      v = s;
      for (int j = 0; j < TW; j++) begin
         e    = '0;
         e[j] = 1'b1;
         p[j*TW +: TW] = step_f(e);
      end
      for (int b = 0; b < 32; b++) begin
         if (((n >> b) & 1) != 0) v = apply_f(p, v);
         for (int j = 0; j < TW; j++) q[j*TW +: TW] = apply_f(p, p[j*TW +: TW]);
         p = q;
      end
      return v;
   endfunction

   localparam logic [TW-1:0] TERM_NORM  = jump_f(SEED, N_NORM);
   localparam logic [TW-1:0] TERM_SHORT = jump_f(SEED, N_SHORT);

   logic [TW-1:0] t_q;
   logic [TW-1:0] term;

   assign term    = short_sel ? TERM_SHORT : TERM_NORM;
   assign expired = !reload && (t_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      t_q <= SEED;
      else if (reload) t_q <= SEED;
      else             t_q <= step_f(t_q);
   end

endmodule

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler
   import desc_pkg::*;
#(
   parameter int unsigned KS_W     = 11,
   parameter int unsigned KS_TAP   = 9,
   parameter int unsigned IDLE_W   = 6,
   parameter int unsigned IDLE_RUN = 30,
   parameter int unsigned TMR_W    = 16,
   parameter int unsigned CLK_MHZ  = 125,
   parameter int unsigned HOLD_US  = 361,
   parameter int unsigned TEST_US  = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] scr_bits,
   input  logic [1:0] scr_cnt,
   input  logic       sig_ok,
   input  logic       short_timeout,
   output logic [1:0] dsc_bits,
   output logic [1:0] dsc_cnt,
   output logic       locked
);

   localparam int unsigned N_NORM  = CLK_MHZ * HOLD_US;
   localparam int unsigned N_SHORT = CLK_MHZ * TEST_US;

   bit_pair_t plain;
   logic      run_ok;
   logic      tmr_exp;

   desc_keystream #(.KS_W(KS_W), .KS_TAP(KS_TAP)) i_ks (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked   (locked),
      .cin      (scr_bits),
      .cnt      (scr_cnt),
      .plain    (plain),
      .out_bits (dsc_bits),
      .out_cnt  (dsc_cnt)
   );

   desc_idle_run #(.IW(IDLE_W), .RUN(IDLE_RUN)) i_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!sig_ok),
      .plain  (plain),
      .cnt    (scr_cnt),
      .run_ok (run_ok)
   );

   desc_unlock_timer #(.TW(TMR_W), .N_NORM(N_NORM), .N_SHORT(N_SHORT)) i_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload    (!locked || run_ok),
      .short_sel (short_timeout),
      .expired   (tmr_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 locked <= 1'b0;
      else if (!sig_ok)           locked <= 1'b0;
      else if (!locked && run_ok) locked <= 1'b1;
      else if (tmr_exp)           locked <= 1'b0;
   end

endmodule

// File: rtl/idle_lock_descrambler_chk.sv
module idle_lock_descrambler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] scr_cnt,
   input logic       sig_ok,
   input logic [1:0] dsc_bits,
   input logic [1:0] dsc_cnt,
   input logic       locked,
   input logic       run_ok,
   input logic       tmr_exp
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   a_r2_count_follows: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> dsc_cnt == $past(scr_cnt));

   a_r3_upper_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_cnt != 2'd2) |-> !dsc_bits[1]);

   a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_cnt == 2'd0) |-> dsc_bits == 2'b00);

   a_r6_lock_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(locked)) |-> $past(run_ok && sig_ok));

   a_r8_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $fell(locked)) |-> $past(!sig_ok || tmr_exp));

   a_r10_run_holds_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && run_ok && sig_ok) |=> locked);

   a_r11_status_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(sig_ok)) |-> !locked);

endmodule

bind idle_lock_descrambler idle_lock_descrambler_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scr_cnt  (scr_cnt),
   .sig_ok   (sig_ok),
   .dsc_bits (dsc_bits),
   .dsc_cnt  (dsc_cnt),
   .locked   (locked),
   .run_ok   (run_ok),
   .tmr_exp  (tmr_exp)
);

// File: tb/test_idle_lock_descrambler.sv
module test_idle_lock_descrambler;

   localparam int CLK_PERIOD = 8;
   localparam int N_NORM     = 125 * 361;
   localparam int N_SHORT    = 125 * 5;

   // {count[1:0], plaintext[1:0]}
   localparam logic [3:0] VEC [20] = '{
      4'hB, 4'h8, 4'h5, 4'h0, 4'hA, 4'h9, 4'h4, 4'hB, 4'h1, 4'h6,
      4'h8, 4'hB, 4'hB, 4'h7, 4'h2, 4'h9, 4'hA, 4'h5, 4'h8, 4'hB
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] scr_bits = 2'b00;
   logic [1:0] scr_cnt = 2'b00;
   logic       sig_ok = 1'b1;
   logic       short_timeout = 1'b0;
   logic [1:0] dsc_bits;
   logic [1:0] dsc_cnt;
   logic       locked;

   logic [10:0] bks = 11'h2D5;
   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idle_lock_descrambler i_idle_lock_descrambler (
      .clk           (clk),
      .rst_n         (rst_n),
      .scr_bits      (scr_bits),
      .scr_cnt       (scr_cnt),
      .sig_ok        (sig_ok),
      .short_timeout (short_timeout),
      .dsc_bits      (dsc_bits),
      .dsc_cnt       (dsc_cnt),
      .locked        (locked)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive one cycle at a negedge, then sample at the next negedge
   task automatic drive(input logic [1:0] cnt, input logic [1:0] pl,
                        input bit chk_data, input bit chk_cnt);
      logic [1:0] cb;
      logic [1:0] expd;
      logic       k;
      cb   = 2'b11;
      expd = 2'b00;
      for (int i = 0; i < 2; i++) begin
         if ((i == 0 && cnt != 2'd0) || (i == 1 && cnt == 2'd2)) begin
            k     = bks[10] ^ bks[8];
            cb[i] = pl[i] ^ k;
            expd[i] = pl[i];
            bks   = {bks[9:0], k};
         end
      end
      scr_bits = cb;
      scr_cnt  = cnt;
      @(negedge clk);
      if (chk_cnt)
         check(dsc_cnt == cnt, "R2", "output count", 32'(dsc_cnt), 32'(cnt));
      if (chk_data)
         check(dsc_bits == expd, "R4", "descrambled bits", 32'(dsc_bits), 32'(expd));
   endtask

   task automatic idles(input int n);
      for (int i = 0; i < n; i++) drive(2'd2, 2'b11, 1'b0, 1'b0);
   endtask

   task automatic zeros(input int n);
      for (int i = 0; i < n; i++) drive(2'd2, 2'b00, 1'b0, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: run did not complete actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      bit seen;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(locked == 1'b0 && dsc_cnt == 2'd0 && dsc_bits == 2'd0, "R1",
            "outputs in reset", {29'd0, locked, dsc_cnt}, 32'd0);
      rst_n = 1'b1;
      check(locked == 1'b0 && dsc_cnt == 2'd0, "R1", "outputs after release",
            {29'd0, locked, dsc_cnt}, 32'd0);

      // R6: acquisition from two idle bits per clock
      idles(15);
      check(locked == 1'b0, "R6", "unlocked after 15 clocks", 32'(locked), 32'd0);
      idles(7);
      check(locked == 1'b1, "R6", "locked after 22 clocks", 32'(locked), 32'd1);

      // R3 R4 R5: vector table while locked
      foreach (VEC[i]) drive(VEC[i][3:2], VEC[i][1:0], 1'b1, 1'b1);
      check(locked == 1'b1, "R5", "lock kept through table", 32'(locked), 32'd1);

      // R11: status drop in the same cycle as two bits of data
      sig_ok = 1'b0;
      drive(2'd2, 2'b11, 1'b0, 1'b1);
      check(locked == 1'b0, "R11", "status loss unlocks", 32'(locked), 32'd0);
      sig_ok = 1'b1;

      // R7: runs broken by a zero bit never lock
      seen = 0;
      for (int r = 0; r < 6; r++) begin
         idles(9);
         seen |= locked;
         drive(2'd2, 2'b10, 1'b0, 1'b1);
         seen |= locked;
      end
      check(seen == 1'b0, "R7", "short runs never lock", 32'(seen), 32'd0);

      // R7 R5: run spanning mixed counts including 0
      for (int r = 0; r < 12; r++) begin
         drive(2'd1, 2'b11, 1'b0, 1'b1);
         drive(2'd2, 2'b11, 1'b0, 1'b1);
         drive(2'd0, 2'b11, 1'b0, 1'b1);
         drive(2'd2, 2'b11, 1'b0, 1'b1);
      end
      check(locked == 1'b1, "R7", "mixed-count run locks", 32'(locked), 32'd1);
      for (int i = 0; i < 6; i++) drive(i[0] ? 2'd1 : 2'd0, 2'b01, 1'b1, 1'b1);

      // R9: short window
      short_timeout = 1'b1;
      idles(20);
      zeros(1);
      zeros(N_SHORT);
      check(locked == 1'b1, "R9", "held until short window end", 32'(locked), 32'd1);
      zeros(1);
      check(locked == 1'b0, "R9", "cleared after short window", 32'(locked), 32'd0);

      // R8: normal window
      short_timeout = 1'b0;
      idles(30);
      check(locked == 1'b1, "R8", "relocked", 32'(locked), 32'd1);
      zeros(1);
      zeros(N_NORM);
      check(locked == 1'b1, "R8", "held until normal window end", 32'(locked), 32'd1);
      zeros(1);
      check(locked == 1'b0, "R8", "cleared after normal window", 32'(locked), 32'd0);

      // R10: repeated runs keep restarting the short window
      short_timeout = 1'b1;
      idles(30);
      check(locked == 1'b1, "R10", "relocked", 32'(locked), 32'd1);
      for (int r = 0; r < 4; r++) begin
         zeros(300);
         idles(20);
      end
      check(locked == 1'b1, "R10", "lock kept past short window", 32'(locked), 32'd1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule